// File: doc/BRIEF.md
# I/O Address Translation Buffer

This block is a sixteen-entry, fully associative translation cache sitting in front of a DMA path. It turns a 32-bit DMA virtual address into a 34-bit physical address with 8 KB pages. Requests arrive on a valid/ready lookup channel. Each one gets exactly one answer on a valid/ready response channel, which carries the physical address and a status code.

When the lookup misses, the block raises a fill request carrying the virtual page number. It then waits for the refill on a fill channel and writes the refill into a victim entry. Each entry has a used bit, and replacement approximates least-recently-used from those bits. Software can pin the lowest entries through a lock pointer.

A control word holds the following settings:
- the enable
- diagnostic mode
- the page-size and table-size settings, which are stored for the walker outside the block
- locking
- a sticky error flag with its code

In diagnostic mode every entry's tag and data word can be read and written directly through a small register port.

Top module: `iotlb_top`

## Requirements
- R1: While the enable (control bit 0) is clear, a lookup answers with the virtual address zero-extended to 34 bits and status OK (0). It raises no fill request, and the answer is valid in the second cycle after acceptance.
- R2: An entry hits when its data word valid bit (30) is set and its tag bits [18:0] equal virtual address bits [31:13]. A hit answers with {data bits [20:0], address bits [12:0]} and status OK, valid in the second cycle after acceptance.
- R3: A miss raises a fill request carrying address bits [31:13]. A good refill is written to the victim entry with the valid and used bits set, and the lookup is answered with the refilled translation.
- R4: A write lookup that resolves to an entry whose tag writable bit (21) is clear answers with status protection fault (1) and address 0. This holds both on a hit and after a refill.
- R5: A refill flagged as erroneous does three things. It answers with status fill error (2) and address 0. It writes the victim tag with error bit 22, the error code in bits [24:23] and the page number, and it writes the data word as 0. It also sets control bit 24 with the code in control bits [26:25].
- R6: Writing 1 to control bit 24 clears the error flag and its code. The other control fields (bits 0, 1, 2, [18:16], [22:19], 23) take the written value.
- R7: The register address is {sel[1:0], index[3:0]}, with sel 0 for control, 1 for a tag word and 2 for a data word. Tag and data words are read and written only while diagnostic mode (control bit 1) is set. Otherwise they read as 0 and writes to them are ignored.
- R8: Writing zero to an entry's tag and data words invalidates it, so a later lookup of its page misses.
- R9: A hit or a good refill sets that entry's used bit. If every unlocked entry is then used, the used bits of all unlocked entries except that one are cleared.
- R10: The victim is the lowest-index invalid eligible entry; failing that, the lowest-index eligible entry whose used bit is clear.
- R11: While lock enable (control bit 23) is set, entries with an index below the lock pointer (control bits [22:19]) are never chosen as victims.
- R12: A response and a fill request, once raised, hold steady until accepted. No new lookup is accepted while a lookup is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted (block idle) |
| lk_vaddr | input | 32 | DMA virtual address |
| lk_write | input | 1 | Lookup is for a write access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted by the requester |
| rsp_paddr | output | 34 | Translated physical address |
| rsp_status | output | 2 | 0 OK, 1 protection fault, 2 fill error |
| fr_valid | output | 1 | Fill request valid |
| fr_ready | input | 1 | Fill request accepted by the walker |
| fr_vpn | output | 19 | Virtual page number to fetch |
| fl_valid | input | 1 | Refill valid |
| fl_ready | output | 1 | Block is waiting for a refill |
| fl_ppn | input | 21 | Refilled physical page number |
| fl_writable | input | 1 | Refilled page may be written |
| fl_cacheable | input | 1 | Refilled page is cacheable |
| fl_err | input | 1 | Refill failed |
| fl_errcode | input | 2 | Failure code (1 invalid entry, 3 ECC) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address {sel, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench fills all sixteen entries and then touches fifteen of them. With those touches it shows that the sixteenth hit wipes the other used bits. A design that forgot the wipe would stall replacement on entry 15 forever, and one that wiped the hit entry too would evict the page it just used. Further tests check the following:
- A miss after the wipe lands on the lowest unused slot.
- An invalidated middle entry is preferred over unused ones.
- With the lock pointer at 4, the victim skips slots 1 to 3, which a design ignoring the lock would overwrite.
- Error refills leave an invalid entry carrying the code, and raise the sticky flag, which a single write of 1 clears.
- Diagnostic writes made with diagnostic mode off must not land.
- A response held under back-pressure must neither change nor let a second lookup in.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  // tag word fields
  localparam int T_SIZE  = 19;
  localparam int T_STRM  = 20;
  localparam int T_WR    = 21;
  localparam int T_ERR   = 22;
  localparam int T_ES    = 23;
  // data word fields
  localparam int D_CACHE = 28;
  localparam int D_USED  = 29;
  localparam int D_VALID = 30;
  // control word fields
  localparam int C_EN    = 0;
  localparam int C_DIAG  = 1;
  localparam int C_TBW   = 2;
  localparam int C_TSZ   = 16;
  localparam int C_LPTR  = 19;
  localparam int C_LEN   = 23;
  localparam int C_ERRF  = 24;
  localparam int C_ES    = 25;
  localparam int LP_W    = 4;

  localparam logic [31:0] TAG_MASK  = 32'h01FF_FFFF;
  localparam logic [31:0] DATA_MASK = 32'h701F_FFFF;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_TAG  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_PROT = 2'd1,
    RSP_FERR = 2'd2
  } rsp_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } tlb_state_e;
endpackage

// File: rtl/iotlb_entries.sv
module iotlb_entries
  import iotlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4,
  parameter int VPN_W = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  diag_tag_we,
  input  logic                  diag_data_we,
  input  logic [IDX_W-1:0]      diag_idx,
  input  logic [31:0]           diag_wdata,
  input  logic                  fill_we,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [31:0]           fill_tag,
  input  logic [31:0]           fill_data,
  input  logic                  used_we,
  input  logic [N-1:0]          used_new,
  input  logic [VPN_W-1:0]      look_vpn,
  output logic [N-1:0][31:0]    tag_q,
  output logic [N-1:0][31:0]    data_q,
  output logic [N-1:0]          valid_vec,
  output logic [N-1:0]          used_vec,
  output logic [N-1:0]          hit_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (fill_we && fill_idx == IDX_W'(i)) begin
          tag_q[i]  <= fill_tag & TAG_MASK;
          data_q[i] <= fill_data & DATA_MASK;
        end else begin
          if (diag_tag_we && diag_idx == IDX_W'(i))
            tag_q[i] <= diag_wdata & TAG_MASK;
          if (diag_data_we && diag_idx == IDX_W'(i))
            data_q[i] <= diag_wdata & DATA_MASK;
        end
        if (used_we)
          data_q[i][D_USED] <= used_new[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign valid_vec[i] = data_q[i][D_VALID];
    assign used_vec[i]  = data_q[i][D_USED];
    assign hit_vec[i]   = data_q[i][D_VALID] && (tag_q[i][VPN_W-1:0] == look_vpn);
  end
endmodule

// File: rtl/iotlb_policy.sv
module iotlb_policy
  import iotlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     used_vec,
  input  logic             lock_en,
  input  logic [LP_W-1:0]  lock_ptr,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [N-1:0]     used_new,
  output logic [IDX_W-1:0] victim_idx
);
  logic [N-1:0] elig, touched, used_set, cand_inv, cand_unu;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign elig[i]    = !(lock_en && (i < int'(lock_ptr)));
    assign touched[i] = (touch_idx == IDX_W'(i));
  end

  assign used_set = used_vec | touched;
  assign cand_inv = ~valid_vec & elig;
  assign cand_unu = ~used_vec & elig;

  always_comb begin
    if ((used_set & elig) == elig)
      used_new = (used_set & ~elig) | touched;
    else
      used_new = used_set;
  end

  // later loops override earlier ones: invalid beats unused beats any eligible
  always_comb begin
    victim_idx = IDX_W'(N - 1);
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) victim_idx = IDX_W'(i);
    for (int i = N - 1; i >= 0; i--)
      if (cand_unu[i]) victim_idx = IDX_W'(i);
    for (int i = N - 1; i >= 0; i--)
      if (cand_inv[i]) victim_idx = IDX_W'(i);
  end
endmodule

// File: rtl/iotlb_top.sv
module iotlb_top
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 34,
  parameter int PAGE_SH = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid,
  output logic                         lk_ready,
  input  logic [VA_W-1:0]              lk_vaddr,
  input  logic                         lk_write,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [PA_W-1:0]              rsp_paddr,
  output logic [1:0]                   rsp_status,
  output logic                         fr_valid,
  input  logic                         fr_ready,
  output logic [VA_W-PAGE_SH-1:0]      fr_vpn,
  input  logic                         fl_valid,
  output logic                         fl_ready,
  input  logic [PA_W-PAGE_SH-1:0]      fl_ppn,
  input  logic                         fl_writable,
  input  logic                         fl_cacheable,
  input  logic                         fl_err,
  input  logic [1:0]                   fl_errcode,
  input  logic                         reg_wr,
  input  logic [$clog2(ENTRIES)+1:0]   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PAGE_SH;
  localparam int PPN_W = PA_W - PAGE_SH;

  // control fields
  logic            en_q, diag_q, tbw_q, len_q, errf_q;
  logic [2:0]      tsz_q;
  logic [LP_W-1:0] lptr_q;
  logic [1:0]      errs_q;
  logic [31:0]     ctrl_word;

  // lookup pipeline
  tlb_state_e      state_q;
  logic [VA_W-1:0] vaddr_q;
  logic            write_q;
  logic [IDX_W-1:0] victim_q;
  logic [PA_W-1:0] paddr_q;
  logic [1:0]      status_q;

  // entry array wiring
  logic [ENTRIES-1:0][31:0] tag_q, data_q;
  logic [ENTRIES-1:0] valid_vec, used_vec, hit_vec, used_new;
  logic [IDX_W-1:0]   hit_idx, victim_idx, touch_idx;
  logic               hit_any, used_we, fill_we;
  logic [31:0]        fill_tag, fill_data;
  logic [1:0]         sel;
  logic [IDX_W-1:0]   ridx;
  logic               diag_tag_we, diag_data_we, ctrl_we;
  logic [VPN_W-1:0]   vpn_q;

  assign vpn_q = vaddr_q[VA_W-1:PAGE_SH];
  assign sel   = reg_addr[IDX_W+1:IDX_W];
  assign ridx  = reg_addr[IDX_W-1:0];

  assign ctrl_we      = reg_wr && (sel == SEL_CTRL);
  assign diag_tag_we  = reg_wr && diag_q && (sel == SEL_TAG);
  assign diag_data_we = reg_wr && diag_q && (sel == SEL_DATA);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[C_EN]             = en_q;
    ctrl_word[C_DIAG]           = diag_q;
    ctrl_word[C_TBW]            = tbw_q;
    ctrl_word[C_TSZ+2:C_TSZ]    = tsz_q;
    ctrl_word[C_LPTR+LP_W-1:C_LPTR] = lptr_q;
    ctrl_word[C_LEN]            = len_q;
    ctrl_word[C_ERRF]           = errf_q;
    ctrl_word[C_ES+1:C_ES]      = errs_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_TAG:  reg_rdata = diag_q ? tag_q[ridx]  : '0;
      SEL_DATA: reg_rdata = diag_q ? data_q[ridx] : '0;
      default:  reg_rdata = '0;
    endcase
  end

  // lowest-index hit
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
  assign hit_any = |hit_vec;

  assign fill_we   = (state_q == ST_FWAIT) && fl_valid;
  assign touch_idx = (state_q == ST_LOOK) ? hit_idx : victim_q;
  assign used_we   = ((state_q == ST_LOOK) && en_q && hit_any) ||
                     (fill_we && !fl_err);

  always_comb begin
    fill_tag = '0;
    fill_tag[VPN_W-1:0]   = vpn_q;
    fill_tag[T_WR]        = fl_writable && !fl_err;
    fill_tag[T_ERR]       = fl_err;
    fill_tag[T_ES+1:T_ES] = fl_err ? fl_errcode : 2'd0;
  end

  always_comb begin
    fill_data = '0;
    fill_data[PPN_W-1:0] = fl_err ? '0 : fl_ppn;
    fill_data[D_CACHE]   = fl_cacheable && !fl_err;
    fill_data[D_USED]    = !fl_err;
    fill_data[D_VALID]   = !fl_err;
  end

  iotlb_entries #(.N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_entries (
    .clk         (clk),
    .rst_n       (rst_n),
    .diag_tag_we (diag_tag_we),
    .diag_data_we(diag_data_we),
    .diag_idx    (ridx),
    .diag_wdata  (reg_wdata),
    .fill_we     (fill_we),
    .fill_idx    (victim_q),
    .fill_tag    (fill_tag),
    .fill_data   (fill_data),
    .used_we     (used_we),
    .used_new    (used_new),
    .look_vpn    (vpn_q),
    .tag_q       (tag_q),
    .data_q      (data_q),
    .valid_vec   (valid_vec),
    .used_vec    (used_vec),
    .hit_vec     (hit_vec)
  );

  iotlb_policy #(.N(ENTRIES), .IDX_W(IDX_W)) u_policy (
    .valid_vec (valid_vec),
    .used_vec  (used_vec),
    .lock_en   (len_q),
    .lock_ptr  (lptr_q),
    .touch_idx (touch_idx),
    .used_new  (used_new),
    .victim_idx(victim_idx)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; diag_q <= 1'b0; tbw_q <= 1'b0; len_q <= 1'b0;
      tsz_q <= '0; lptr_q <= '0; errf_q <= 1'b0; errs_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_q   <= reg_wdata[C_EN];
        diag_q <= reg_wdata[C_DIAG];
        tbw_q  <= reg_wdata[C_TBW];
        tsz_q  <= reg_wdata[C_TSZ+2:C_TSZ];
        lptr_q <= reg_wdata[C_LPTR+LP_W-1:C_LPTR];
        len_q  <= reg_wdata[C_LEN];
        if (reg_wdata[C_ERRF]) begin
          errf_q <= 1'b0;
          errs_q <= '0;
        end
      end
      if (fill_we && fl_err) begin
        errf_q <= 1'b1;
        errs_q <= fl_errcode;
      end
    end
  end

  // lookup sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vaddr_q  <= '0;
      write_q  <= 1'b0;
      victim_q <= '0;
      paddr_q  <= '0;
      status_q <= RSP_OK;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (lk_valid) begin
            vaddr_q <= lk_vaddr;
            write_q <= lk_write;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!en_q) begin
            paddr_q  <= PA_W'(vaddr_q);
            status_q <= RSP_OK;
            state_q  <= ST_RESP;
          end else if (hit_any) begin
            if (write_q && !tag_q[hit_idx][T_WR]) begin
              paddr_q  <= '0;
              status_q <= RSP_PROT;
            end else begin
              paddr_q  <= {data_q[hit_idx][PPN_W-1:0], vaddr_q[PAGE_SH-1:0]};
              status_q <= RSP_OK;
            end
            state_q <= ST_RESP;
          end else begin
            victim_q <= victim_idx;
            state_q  <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (fr_ready) state_q <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (fl_valid) begin
            if (fl_err) begin
              paddr_q  <= '0;
              status_q <= RSP_FERR;
            end else if (write_q && !fl_writable) begin
              paddr_q  <= '0;
              status_q <= RSP_PROT;
            end else begin
              paddr_q  <= {fl_ppn, vaddr_q[PAGE_SH-1:0]};
              status_q <= RSP_OK;
            end
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lk_ready   = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_paddr  = paddr_q;
  assign rsp_status = status_q;
  assign fr_valid   = (state_q == ST_FREQ);
  assign fr_vpn     = vpn_q;
  assign fl_ready   = (state_q == ST_FWAIT);
endmodule

// File: rtl/iotlb_checker.sv
module iotlb_checker #(
  parameter int PA_W  = 34,
  parameter int VPN_W = 19,
  parameter int IDX_W = 4,
  parameter int LP_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_status,
  input logic             fr_valid,
  input logic             fr_ready,
  input logic [VPN_W-1:0] fr_vpn,
  input logic             fl_valid,
  input logic             fl_ready,
  input logic             fl_err,
  input logic             en_q,
  input logic             errf_q,
  input logic             len_q,
  input logic [LP_W-1:0]  lptr_q,
  input logic [IDX_W-1:0] victim_q
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)); // R12
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && !fr_ready |=> fr_valid && $stable(fr_vpn)); // R12
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || fr_valid || fl_ready) |-> !lk_ready); // R12
  AST_NO_FILL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_valid) |-> en_q); // R1
  AST_LOCK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && len_q |-> victim_q >= lptr_q); // R11
  AST_FERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_ready && fl_err |=> errf_q && rsp_valid && rsp_status == 2'd2); // R5
endmodule

bind iotlb_top iotlb_checker #(
  .PA_W (PA_W),
  .VPN_W(VPN_W),
  .IDX_W(IDX_W),
  .LP_W (iotlb_pkg::LP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_ready  (lk_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_status(rsp_status),
  .fr_valid  (fr_valid),
  .fr_ready  (fr_ready),
  .fr_vpn    (fr_vpn),
  .fl_valid  (fl_valid),
  .fl_ready  (fl_ready),
  .fl_err    (fl_err),
  .en_q      (en_q),
  .errf_q    (errf_q),
  .len_q     (len_q),
  .lptr_q    (lptr_q),
  .victim_q  (victim_q)
);

// File: tb/tb_iotlb_top.sv
module tb_iotlb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, lk_valid, lk_ready, lk_write, rsp_valid, rsp_ready;
  logic [31:0] lk_vaddr, reg_wdata, reg_rdata;
  logic [33:0] rsp_paddr;
  logic [1:0]  rsp_status, fl_errcode;
  logic fr_valid, fr_ready, fl_valid, fl_ready, fl_writable, fl_cacheable, fl_err, reg_wr;
  logic [18:0] fr_vpn;
  logic [20:0] fl_ppn;
  logic [5:0]  reg_addr;

  iotlb_top dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] va; logic wr; logic xfill; logic [20:0] ppn;
    logic fwr; logic ferr; logic [1:0] fcode; logic [33:0] pa; logic [1:0] st;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_2004, 1'b0, 1'b1, 21'h00100, 1'b1, 1'b0, 2'd0, 34'h0_0020_0004, 2'd0},
    '{32'h0000_3FFC, 1'b0, 1'b0, 21'h0,     1'b0, 1'b0, 2'd0, 34'h0_0020_1FFC, 2'd0},
    '{32'h0040_0000, 1'b1, 1'b1, 21'h1ABCD, 1'b0, 1'b0, 2'd0, 34'h0,           2'd1},
    '{32'h0040_0010, 1'b0, 1'b0, 21'h0,     1'b0, 1'b0, 2'd0, 34'h0_3579_A010, 2'd0},
    '{32'h0060_0000, 1'b0, 1'b1, 21'h0,     1'b0, 1'b1, 2'd3, 34'h0,           2'd2},
    '{32'h0060_0008, 1'b0, 1'b1, 21'h1FFFFF,1'b1, 1'b0, 2'd0, 34'h3_FFFF_E008, 2'd0},
    '{32'h0040_0020, 1'b1, 1'b0, 21'h0,     1'b0, 1'b0, 2'd0, 34'h0,           2'd1},
    '{32'h0000_2000, 1'b1, 1'b0, 21'h0,     1'b0, 1'b0, 2'd0, 34'h0_0020_0000, 2'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic [20:0] ppn,
                        input logic fwr, input logic ferr, input logic [1:0] fcode, input int hold,
                        output logic [33:0] pa, output logic [1:0] st, output logic saw_fill,
                        output int lat);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr;
    fl_ppn = ppn; fl_writable = fwr; fl_cacheable = 1'b0; fl_err = ferr; fl_errcode = fcode;
    while (!lk_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    lat = 1; saw_fill = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (rsp_valid) break;
      if (fr_valid) begin
        saw_fill = 1'b1;
        chk("R3 fill vpn", 64'(fr_vpn), 64'(va[31:13]));
      end
      fl_valid = fl_ready;
      @(negedge clk);
      fl_valid = 1'b0;
      lat++;
    end
    if (!rsp_valid) chk("R12 response arrives", 0, 1);
    pa = rsp_paddr; st = rsp_status;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R12 response held", {rsp_valid, lk_ready}, 2'b10);
      chk("R12 paddr stable", 64'(rsp_paddr), 64'(pa));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [33:0] pa; logic [1:0] st; logic sf; int lat; logic [31:0] rd;
    rst_n = 1'b0; lk_valid = 0; lk_vaddr = 0; lk_write = 0; rsp_ready = 0;
    fr_ready = 1'b1; fl_valid = 0; fl_ppn = 0; fl_writable = 0; fl_cacheable = 0;
    fl_err = 0; fl_errcode = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset outputs", {lk_ready, rsp_valid, fr_valid, fl_ready}, 4'b1000);
    reg_read(6'h00, rd); chk("R6 reset control", 64'(rd), 0);
    reg_write(6'h00, 32'h1);

    // main vector table (R2 R3 R4 R5)
    for (int v = 0; v < 8; v++) begin
      lookup(VEC[v].va, VEC[v].wr, VEC[v].ppn, VEC[v].fwr, VEC[v].ferr, VEC[v].fcode, 0, pa, st, sf, lat);
      chk($sformatf("R2 R3 vec%0d fill seen", v), 64'(sf), 64'(VEC[v].xfill));
      chk($sformatf("R2 R4 vec%0d paddr", v), 64'(pa), 64'(VEC[v].pa));
      chk($sformatf("R4 R5 vec%0d status", v), 64'(st), 64'(VEC[v].st));
      if (!VEC[v].xfill) chk($sformatf("R2 vec%0d latency", v), 64'(lat), 2);
    end

    // R5/R6 sticky error flag with code, write-1-to-clear
    reg_read(6'h00, rd); chk("R5 control error flag", 64'(rd), 64'h0700_0001);
    reg_write(6'h00, 32'h0100_0001);
    reg_read(6'h00, rd); chk("R6 flag cleared", 64'(rd), 64'h0000_0001);

    // R7 diag access gated by diagnostic mode
    reg_read(6'h10, rd); chk("R7 tag reads zero without diag", 64'(rd), 0);
    reg_write(6'h15, 32'h0000_0ABC);
    reg_write(6'h00, 32'h3);
    reg_read(6'h15, rd); chk("R7 write ignored without diag", 64'(rd), 0);
    reg_read(6'h10, rd); chk("R7 tag0 read", 64'(rd), 64'h0020_0001);
    reg_read(6'h20, rd); chk("R7 data0 read", 64'(rd), 64'h6000_0100);

    // R5 error refill leaves tagged invalid entry (victim 3)
    lookup(32'h0080_0000, 1'b0, 21'h0, 1'b0, 1'b1, 2'd1, 0, pa, st, sf, lat);
    chk("R5 error status", 64'(st), 2);
    reg_read(6'h13, rd); chk("R5 error tag", 64'(rd), 64'h00C0_0400);
    reg_read(6'h23, rd); chk("R5 error data", 64'(rd), 0);
    reg_read(6'h00, rd); chk("R5 code 1 in control", 64'(rd), 64'h0300_0003);
    reg_write(6'h00, 32'h0100_0003);

    // R9 used-bit aging
    for (int i = 0; i < 16; i++) begin
      reg_write(6'(16 + i), 32'h0020_0010 + 32'(i));
      reg_write(6'(32 + i), 32'h4000_0000 + 32'(i));
    end
    for (int i = 0; i < 15; i++)
      lookup((32'h10 + 32'(i)) << 13, 1'b0, 21'h0, 1'b0, 1'b0, 2'd0, 0, pa, st, sf, lat);
    chk("R9 hit translation", 64'(pa), 64'h0_0001_C000);
    reg_read(6'h2E, rd); chk("R9 used set on hit", 64'(rd), 64'h6000_000E);
    lookup(32'h1F << 13, 1'b0, 21'h0, 1'b0, 1'b0, 2'd0, 0, pa, st, sf, lat);
    reg_read(6'h2F, rd); chk("R9 hit entry keeps used", 64'(rd), 64'h6000_000F);
    reg_read(6'h20, rd); chk("R9 others cleared", 64'(rd), 64'h4000_0000);
    reg_read(6'h2E, rd); chk("R9 entry14 cleared", 64'(rd), 64'h4000_000E);

    // R10 lowest unused victim
    lookup(32'h000A_0000, 1'b0, 21'h77, 1'b1, 1'b0, 2'd0, 0, pa, st, sf, lat);
    chk("R10 refill paddr", 64'(pa), 64'h0_000E_E000);
    reg_read(6'h10, rd); chk("R10 victim entry0", 64'(rd), 64'h0020_0050);

    // R8 invalidate by zero, R10 invalid preferred
    reg_write(6'h13, 32'h0);
    reg_write(6'h23, 32'h0);
    lookup(32'h0002_6000, 1'b0, 21'h33, 1'b1, 1'b0, 2'd0, 0, pa, st, sf, lat);
    chk("R8 invalidated entry misses", 64'(sf), 1);
    reg_read(6'h13, rd); chk("R10 invalid slot reused", 64'(rd), 64'h0020_0013);

    // R11 lock pointer 4
    reg_write(6'h00, 32'h00A0_0003);
    reg_read(6'h00, rd); chk("R11 lock fields", 64'(rd), 64'h00A0_0003);
    lookup(32'h000C_0000, 1'b0, 21'h5, 1'b1, 1'b0, 2'd0, 0, pa, st, sf, lat);
    reg_read(6'h14, rd); chk("R11 victim above lock", 64'(rd), 64'h0020_0060);
    reg_read(6'h11, rd); chk("R11 locked entry1 kept", 64'(rd), 64'h0020_0011);

    // R1 bypass when disabled
    reg_write(6'h00, 32'h0);
    lookup(32'h1234_5678, 1'b1, 21'h0, 1'b0, 1'b0, 2'd0, 0, pa, st, sf, lat);
    chk("R1 bypass paddr", 64'(pa), 64'h0_1234_5678);
    chk("R1 bypass status", 64'(st), 0);
    chk("R1 no fill", 64'(sf), 0);
    chk("R1 latency", 64'(lat), 2);

    // R12 back-pressure on a hit
    reg_write(6'h00, 32'h1);
    lookup(32'h0002_2000, 1'b0, 21'h0, 1'b0, 1'b0, 2'd0, 3, pa, st, sf, lat);
    chk("R12 held response paddr", 64'(pa), 64'h0_0000_2000);
    @(negedge clk);
    chk("R12 idle after accept", {lk_ready, rsp_valid}, 2'b10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule